// File: doc/BRIEF.md
# Memory Checksum Command Engine

This block adds up a region of read-only memory on command from software. Software programs a command code, a byte start address and a byte length through a small word-indexed register port. Nothing happens until it writes the launch bit. A valid launch moves the engine from its idle state into its summing state. The engine then reads one word per cycle through a synchronous read port with one cycle of latency, folds each word into a 32-bit wrapping sum and drops back to idle after the last word has arrived.

Each change of state sets a sticky interrupt flag, so one command gives two interrupt events: one on entry and one on completion. Software clears the flag by writing 1 to it, and a mask bit keeps it off the interrupt pin. A status word reports ready, processing, error and the current state. A launch that cannot be honoured is dropped and leaves an error bit set.

Top module: `memsum_engine`

## Requirements
- R1: After reset the engine is idle. STATUS reads 0x1 (ready only). The result, the interrupt flag and the mask read 0, and `irq` is low.
- R2: Register word indices are: 0 command code [7:0], 1 start address, 2 length in bytes, 3 launch (bit 0, reads 0), 4 status, 5 result, 6 interrupt flag (bit 0), 7 interrupt mask (bit 0). Writing indices 0 to 2 never starts work. A launch starts work only when all of these hold: the engine is idle, the command is 0x5A, and the length is nonzero and a multiple of 4.
- R3: The result is the 32-bit wrapping sum of the words at addresses start+4k for k < length/4. Addresses wrap modulo 2^ADDR_W, and the two low bits of the start address are treated as zero.
- R4: An accepted command issues exactly length/4 reads, at most one per cycle, at ascending consecutive word addresses. With N words, processing ends N+1 cycles after the launch edge.
- R5: The result reads 0 from the launch edge until the first word is added. After completion it holds its value until the next accepted launch.
- R6: The interrupt flag is set on entering the summing state and again on returning to idle. It is sticky and cleared only by writing 1 to index 6 bit 0. Writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R7: `irq` equals the flag while the mask bit is 0, and stays low while the mask bit is 1.
- R8: A launch while busy, with a command other than 0x5A, with length 0 or with length not a multiple of 4 changes neither the state nor the flag, and sets the error bit. The next accepted launch clears the error bit. A launch rejected while busy does not disturb the running sum.
- R9: STATUS bit 0 is ready (idle), bit 1 is processing, bit 2 is error and bit 3 is state (0 idle, 1 summing). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register word index for writes |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register word index for reads |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| irq | output | 1 | Interrupt output (flag gated by mask) |

## Verification
The assertions assume that memory answers every request exactly one cycle later. They also assume that only the engine's own walk produces back-to-back requests, so consecutive requests always differ by one word. The bench memory model answers each request on the following edge with a value computed from the address alone. The bench changes register writes only on falling clock edges, which keeps every launch, clear and rejected launch at a known cycle relative to the walk.

// File: rtl/memsum_pkg.sv
package memsum_pkg;

    localparam int WORD_W = 32;
    localparam int RIDX_W = 3;

    localparam logic [7:0] CMD_CHECKSUM = 8'h5A;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CSUM = 1'b1
    } mc_state_e;

    typedef enum logic [RIDX_W-1:0] {
        RI_CMD  = 3'd0,
        RI_BASE = 3'd1,
        RI_LEN  = 3'd2,
        RI_KICK = 3'd3,
        RI_STAT = 3'd4,
        RI_SUM  = 3'd5,
        RI_FLAG = 3'd6,
        RI_MASK = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic state_csum;
        logic error;
        logic processing;
        logic ready;
    } status_t;

    function automatic logic [WORD_W-1:0] pack_status(input status_t s);
        return {{(WORD_W-4){1'b0}}, s};
    endfunction

endpackage

// File: rtl/memsum_ctrl.sv
module memsum_ctrl
    import memsum_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic [7:0]       cmd,
    input  logic [LEN_W-1:0] len,
    input  logic             done,
    output mc_state_e        state,
    output logic             start,
    output logic             reject,
    output logic             xition
);

    logic len_ok;

    assign len_ok = (len != '0) && (len[1:0] == 2'b00);
    assign start  = kick && (state == ST_IDLE) && (cmd == CMD_CHECKSUM) && len_ok;
    assign reject = kick && !start;
    assign xition = start || ((state == ST_CSUM) && done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_CSUM;
                ST_CSUM: if (done)  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/memsum_walker.sv
module memsum_walker #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-3:0] nwords,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rvld,
    output logic              done
);

    localparam int WC_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] ptr;
    logic [WC_W-1:0]   iss_left;
    logic [WC_W-1:0]   rsp_left;

    assign mem_req  = (iss_left != '0);
    assign mem_addr = ptr;
    assign done     = rvld && (rsp_left == WC_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            iss_left <= '0;
            rsp_left <= '0;
            rvld     <= 1'b0;
        end else begin
            rvld <= mem_req;
            if (start) begin
                ptr      <= {base[ADDR_W-1:2], 2'b00};
                iss_left <= nwords;
                rsp_left <= nwords;
            end else begin
                if (mem_req) begin
                    ptr      <= ptr + STEP;
                    iss_left <= iss_left - WC_W'(1);
                end
                if (rvld) begin
                    rsp_left <= rsp_left - WC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/memsum_accum.sv
module memsum_accum
    import memsum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] sum
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + din;
        end
    end

endmodule

// File: rtl/memsum_engine.sv
module memsum_engine
    import memsum_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);

    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] len_q;
    logic              flag_q;
    logic              mask_q;
    logic              err_q;

    logic              kick;
    mc_state_e         state;
    logic              start;
    logic              reject;
    logic              xition;
    logic              done;
    logic              rvld;
    logic [WORD_W-1:0] sum;
    status_t           stat;

    assign kick = reg_wr && (reg_idx_e'(reg_waddr) == RI_KICK) && reg_wdata[0];
    assign irq  = flag_q && !mask_q;

    memsum_ctrl #(.LEN_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .kick   (kick),
        .cmd    (cmd_q),
        .len    (len_q),
        .done   (done),
        .state  (state),
        .start  (start),
        .reject (reject),
        .xition (xition)
    );

    memsum_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .base     (base_q),
        .nwords   (len_q[ADDR_W-1:2]),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .rvld     (rvld),
        .done     (done)
    );

    memsum_accum u_acc (
        .clk (clk),
        .rst (rst),
        .clr (start),
        .add (rvld),
        .din (mem_rdata),
        .sum (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            base_q <= '0;
            len_q  <= '0;
            flag_q <= 1'b0;
            mask_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_idx_e'(reg_waddr))
                    RI_CMD:  cmd_q  <= reg_wdata[7:0];
                    RI_BASE: base_q <= reg_wdata[ADDR_W-1:0];
                    RI_LEN:  len_q  <= reg_wdata[ADDR_W-1:0];
                    RI_MASK: mask_q <= reg_wdata[0];
                    RI_FLAG: if (reg_wdata[0]) flag_q <= 1'b0;
                    default: ;
                endcase
            end
            if (xition) flag_q <= 1'b1;
            if (start) begin
                err_q <= 1'b0;
            end else if (reject) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        stat.state_csum = (state == ST_CSUM);
        stat.error      = err_q;
        stat.processing = (state == ST_CSUM);
        stat.ready      = (state == ST_IDLE);
        case (reg_idx_e'(reg_raddr))
            RI_CMD:  reg_rdata = {24'd0, cmd_q};
            RI_BASE: reg_rdata = 32'(base_q);
            RI_LEN:  reg_rdata = 32'(len_q);
            RI_STAT: reg_rdata = pack_status(stat);
            RI_SUM:  reg_rdata = sum;
            RI_FLAG: reg_rdata = {31'd0, flag_q};
            RI_MASK: reg_rdata = {31'd0, mask_q};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/memsum_checker.sv
module memsum_checker
    import memsum_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input mc_state_e         state,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              flag,
    input logic              mask,
    input logic [31:0]       sum,
    input logic              kick,
    input logic              err
);

    logic past_vld;

    always_ff @(posedge clk) begin
        if (rst) past_vld <= 1'b0;
        else     past_vld <= 1'b1;
    end

    AST_REQ_IN_CSUM: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (state == ST_CSUM));  // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (past_vld && mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));  // R4

    AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (past_vld && (state != $past(state))) |-> flag);  // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        mask |-> !irq);  // R7

    AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (kick && (state != ST_IDLE)) |=> err);  // R8

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_vld && ($past(state) == ST_IDLE) && (state == ST_IDLE)) |-> $stable(sum));  // R5

endmodule

bind memsum_engine memsum_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .irq      (irq),
    .flag     (flag_q),
    .mask     (mask_q),
    .sum      (sum),
    .kick     (kick),
    .err      (err_q)
);

// File: tb/sim_memsum_engine.sv
module sim_memsum_engine;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_waddr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [2:0]    reg_raddr = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int req_total = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    memsum_engine #(.ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] memfun(input logic [AW-1:0] a);
        return ({22'd0, a} * 32'h9E3779B1) ^ 32'hA5A50F0F;
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= memfun(mem_addr);
            req_total <= req_total + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_waddr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run(input logic [AW-1:0] base, input int n, input bit busy_kick, input bit msk);
        logic [31:0] v;
        logic [31:0] exp_sum;
        logic [AW-1:0] a;
        int req0;
        exp_sum = '0;
        for (int k = 0; k < n; k++) begin
            a = {base[AW-1:2], 2'b00} + AW'(4 * k);
            exp_sum = exp_sum + memfun(a);
        end
        wr(3'd1, 32'(base));
        wr(3'd2, 32'(4 * n));
        wr(3'd7, {31'd0, msk});
        wr(3'd6, 32'd1);
        req0 = req_total;
        wr(3'd3, 32'd1);
        rd(3'd4, v); check("R2 entry status", v, 32'hA);
        rd(3'd5, v); check("R5 result cleared", v, 32'd0);
        rd(3'd6, v); check("R6 flag on entry", v, 32'd1);
        if (busy_kick) wr(3'd3, 32'd1);
        else           wr(3'd6, 32'd1);
        rd(3'd4, v);
        check("R8 busy kick status", v, busy_kick ? 32'hE : 32'hA);
        if (!busy_kick) begin
            rd(3'd6, v); check("R6 flag cleared", v, 32'd0);
        end
        repeat (n - 1) @(negedge clk);
        rd(3'd4, v); check("R4 still processing", v & 32'h2, 32'h2);
        @(negedge clk);
        rd(3'd4, v); check("R4 done status", v, busy_kick ? 32'h5 : 32'h1);
        rd(3'd5, v); check("R3 result", v, exp_sum);
        rd(3'd6, v); check("R6 flag on exit", v, 32'd1);
        check("R7 irq", {31'd0, irq}, {31'd0, !msk});
        check("R4 read count", 32'(req_total - req0), 32'(n));
        repeat (3) @(negedge clk);
        rd(3'd5, v); check("R5 result held", v, exp_sum);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep;
        int r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(3'd4, v); check("R1 status", v, 32'h1);
        check("R9 status reset bits", v & 32'hFFFF_FFF0, 32'd0);
        rd(3'd5, v); check("R1 result", v, 32'd0);
        rd(3'd6, v); check("R1 flag", v, 32'd0);
        rd(3'd7, v); check("R1 mask", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        r0 = req_total;
        wr(3'd0, 32'h5A);
        wr(3'd1, 32'h40);
        wr(3'd2, 32'd8);
        @(negedge clk);
        rd(3'd4, v); check("R2 no start without launch", v, 32'h1);
        check("R2 no reads", 32'(req_total - r0), 32'd0);
        rd(3'd3, v); check("R2 launch reads zero", v, 32'd0);

        for (int bi = 0; bi < 4; bi++) begin
            for (int n = 1; n <= 6; n++) begin
                logic [AW-1:0] b;
                case (bi)
                    0: b = 10'h000;
                    1: b = 10'h104;
                    2: b = 10'h3F0;
                    default: b = 10'h203;
                endcase
                run(b, n, (n % 2) == 0, n == 3);
            end
        end

        rd(3'd5, keep);
        wr(3'd6, 32'd0);
        rd(3'd6, v); check("R6 write zero keeps flag", v, 32'd1);
        wr(3'd6, 32'd1);

        wr(3'd0, 32'h11);
        wr(3'd2, 32'd16);
        r0 = req_total;
        wr(3'd3, 32'd1);
        rd(3'd4, v); check("R8 bad command", v, 32'h5);
        rd(3'd6, v); check("R8 bad command no flag", v, 32'd0);
        rd(3'd5, v); check("R8 result kept", v, keep);
        check("R8 no reads", 32'(req_total - r0), 32'd0);

        wr(3'd0, 32'h5A);
        wr(3'd2, 32'd0);
        wr(3'd3, 32'd1);
        rd(3'd4, v); check("R8 zero length", v, 32'h5);
        wr(3'd2, 32'd6);
        wr(3'd3, 32'd1);
        rd(3'd4, v); check("R8 unaligned length", v, 32'h5);
        rd(3'd6, v); check("R8 no flag after rejects", v, 32'd0);

        run(10'h3FC, 2, 1'b0, 1'b0);
        rd(3'd4, v); check("R8 error cleared by accept", v, 32'h1);
        wr(3'd7, 32'd1);
        check("R7 mask gates irq", {31'd0, irq}, 32'd0);
        wr(3'd7, 32'd0);
        check("R7 unmask irq", {31'd0, irq}, 32'd1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule